// File: doc/BRIEF.md
# Two-Agent Hardware Ownership Semaphore

This block lets two independent masters, a main processor and a management firmware core, share one converter without stepping on each other. It holds a single shared semaphore register in which each master owns one busy flag. A master claims the converter by setting its own flag and then polling the register until the other master's flag reads clear; it gives the converter back by clearing its own flag with a masked write that leaves every other bit alone. The remaining low bits of the register are ordinary shared storage that either master may update through the same masked write port.

Alongside the flags the block computes a registered grant for each master, so the converter's datapath can be gated in hardware. A grant is sticky: once a master holds it, it keeps it for as long as its flag stays set, even if the other master raises its flag meanwhile. When both flags appear in the same cycle with nobody holding the converter, the firmware core wins and a one-cycle conflict pulse is raised. A per-master watchdog counter flags a master that has been waiting with a pending claim for a programmable number of cycles; the watchdog can be left out of the build with a parameter.

The asynchronous active-low reset is released synchronously inside the block through a two-stage synchronizer, so the state leaves reset two rising edges after the reset input goes high.

Top module: `hw_own_sema`

## Requirements
- R1: After reset the semaphore register reads all zeros and both grants, the conflict pulse and both timeouts are low.
- R2: The processor's flag is bit 14 and the firmware's flag is bit 15 of the semaphore register; a write shows up on the register output after the rising edge that takes it.
- R3: Each master can change only its own flag; a write whose mask selects the other master's flag bit leaves that bit unchanged.
- R4: A write changes only the bits whose mask bit is 1, so clearing a master's own flag leaves all other bits unchanged; where both masters write the same low bit in one cycle, the firmware's value is stored.
- R5: A master whose flag is set while the other's flag is clear and nobody holds the grant receives its grant one rising edge after its flag appears in the register.
- R6: A master holding the grant keeps it for as long as its own flag stays set, even when the other master sets its flag; the other master waits.
- R7: When the holder clears its flag, its grant falls one edge later, and a master whose flag is set receives the grant on that same edge.
- R8: When both flags are set with nobody holding the grant, the firmware core receives the grant and the conflict output is high for exactly one cycle, aligned with that grant.
- R9: The two grant outputs are never high at the same time.
- R10: A master waiting with its flag set and no grant raises its timeout output once it has waited the programmed limit in cycles (limit edges after waiting starts); the timeout falls when it is granted or drops its flag, and a limit of 0 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_wr_data | input | REG_W | Processor write data |
| cpu_wr_mask | input | REG_W | Processor bit mask, 1 = update this bit |
| fw_wr_en | input | 1 | Firmware write strobe |
| fw_wr_data | input | REG_W | Firmware write data |
| fw_wr_mask | input | REG_W | Firmware bit mask, 1 = update this bit |
| wd_limit | input | WD_W | Watchdog limit in cycles, 0 disables |
| sema_rd | output | REG_W | Current semaphore register, visible to both masters |
| cpu_grant | output | 1 | Processor holds the converter |
| fw_grant | output | 1 | Firmware core holds the converter |
| conflict | output | 1 | One-cycle pulse on a simultaneous claim |
| cpu_timeout | output | 1 | Processor has waited past the limit |
| fw_timeout | output | 1 | Firmware core has waited past the limit |

## Verification
A write is due on the register output right after the edge that takes it, while grants and the conflict pulse come one edge later because they are computed from the stored flags; a timeout comes exactly the limit number of edges after the first cycle a master spends waiting. The bench drives every input on the falling edge and samples on a later falling edge after counting the intervening rising edges, checking both the cycle before a result is due (still old value) and the cycle it is due. The contention, tie and watchdog scenarios each check the edge on which the grant changes hands, so an off-by-one in the grant or counter path shows up as a mismatch.

// File: rtl/sema_pkg.sv
`timescale 1ns/1ps
package sema_pkg;
  localparam int unsigned DEF_CPU_BIT = 14;
  localparam int unsigned DEF_FW_BIT  = 15;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_FW   = 2'd2
  } owner_e;
endpackage

// File: rtl/sema_rst_sync.sv
`timescale 1ns/1ps
module sema_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/sema_flag_reg.sv
`timescale 1ns/1ps
module sema_flag_reg #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned CPU_BIT = 14,
  parameter int unsigned FW_BIT  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr_en,
  input  logic [REG_W-1:0] cpu_wr_data,
  input  logic [REG_W-1:0] cpu_wr_mask,
  input  logic             fw_wr_en,
  input  logic [REG_W-1:0] fw_wr_data,
  input  logic [REG_W-1:0] fw_wr_mask,
  output logic [REG_W-1:0] sema_q
);
  localparam logic [REG_W-1:0] ONE      = {{(REG_W-1){1'b0}}, 1'b1};
  localparam logic [REG_W-1:0] CPU_SEL  = ONE << CPU_BIT;
  localparam logic [REG_W-1:0] FW_SEL   = ONE << FW_BIT;

  logic [REG_W-1:0] cpu_eff, fw_eff, sema_d;
  logic             load_en;

  // each master is fenced off from the other's flag bit
  assign cpu_eff = cpu_wr_en ? (cpu_wr_mask & ~FW_SEL)  : '0;
  assign fw_eff  = fw_wr_en  ? (fw_wr_mask  & ~CPU_SEL) : '0;
  assign load_en = (|cpu_eff) | (|fw_eff);

  always_comb begin
    sema_d = sema_q;
    sema_d = (sema_d & ~cpu_eff) | (cpu_wr_data & cpu_eff);
    // firmware applied last: it wins overlapping low bits
    sema_d = (sema_d & ~fw_eff)  | (fw_wr_data  & fw_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sema_q <= '0;
    else if (load_en) sema_q <= sema_d;
  end
endmodule

// File: rtl/sema_grant.sv
`timescale 1ns/1ps
module sema_grant
  import sema_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_flag,
  input  logic fw_flag,
  output logic cpu_grant,
  output logic fw_grant,
  output logic conflict
);
  owner_e own_q, own_d;
  logic   clash_q, clash_d;

  always_comb begin
    own_d   = own_q;
    clash_d = 1'b0;
    unique case (own_q)
      OWN_CPU: if (!cpu_flag) own_d = fw_flag  ? OWN_FW  : OWN_NONE;
      OWN_FW:  if (!fw_flag)  own_d = cpu_flag ? OWN_CPU : OWN_NONE;
      default: begin
        if (fw_flag) begin
          own_d   = OWN_FW;
          clash_d = cpu_flag;
        end else if (cpu_flag) begin
          own_d = OWN_CPU;
        end else begin
          own_d = OWN_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= OWN_NONE;
      clash_q <= 1'b0;
    end else begin
      own_q   <= own_d;
      clash_q <= clash_d;
    end
  end

  assign cpu_grant = (own_q == OWN_CPU);
  assign fw_grant  = (own_q == OWN_FW);
  assign conflict  = clash_q;
endmodule

// File: rtl/sema_wdog.sv
`timescale 1ns/1ps
module sema_wdog #(
  parameter int unsigned WD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            claim,
  input  logic            held,
  input  logic [WD_W-1:0] limit,
  output logic            expired
);
  logic [WD_W-1:0] cnt_q, cnt_d;
  logic            waiting, cnt_en;

  assign waiting = claim & ~held;
  assign cnt_en  = waiting | (cnt_q != '0);

  always_comb begin
    if (!waiting)          cnt_d = '0;
    else if (cnt_q < limit) cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = waiting && (limit != '0) && (cnt_q >= limit);
endmodule

// File: rtl/hw_own_sema.sv
`timescale 1ns/1ps
module hw_own_sema #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned CPU_BIT = sema_pkg::DEF_CPU_BIT,
  parameter int unsigned FW_BIT  = sema_pkg::DEF_FW_BIT,
  parameter int unsigned WD_W    = 16,
  parameter bit          WD_EN   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr_en,
  input  logic [REG_W-1:0] cpu_wr_data,
  input  logic [REG_W-1:0] cpu_wr_mask,
  input  logic             fw_wr_en,
  input  logic [REG_W-1:0] fw_wr_data,
  input  logic [REG_W-1:0] fw_wr_mask,
  input  logic [WD_W-1:0]  wd_limit,
  output logic [REG_W-1:0] sema_rd,
  output logic             cpu_grant,
  output logic             fw_grant,
  output logic             conflict,
  output logic             cpu_timeout,
  output logic             fw_timeout
);
  localparam int unsigned N_AGENT = 2;

  logic               rst_n_int;
  logic [N_AGENT-1:0] claim_v, held_v, tmo_v;

  sema_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sema_flag_reg #(.REG_W(REG_W), .CPU_BIT(CPU_BIT), .FW_BIT(FW_BIT)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_data (cpu_wr_data),
    .cpu_wr_mask (cpu_wr_mask),
    .fw_wr_en    (fw_wr_en),
    .fw_wr_data  (fw_wr_data),
    .fw_wr_mask  (fw_wr_mask),
    .sema_q      (sema_rd)
  );

  sema_grant u_grant (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cpu_flag  (sema_rd[CPU_BIT]),
    .fw_flag   (sema_rd[FW_BIT]),
    .cpu_grant (cpu_grant),
    .fw_grant  (fw_grant),
    .conflict  (conflict)
  );

  assign claim_v = {sema_rd[FW_BIT], sema_rd[CPU_BIT]};
  assign held_v  = {fw_grant, cpu_grant};

  generate
    if (WD_EN) begin : g_wd
      for (genvar a = 0; a < N_AGENT; a++) begin : g_agent
        sema_wdog #(.WD_W(WD_W)) u_wd (
          .clk     (clk),
          .rst_n   (rst_n_int),
          .claim   (claim_v[a]),
          .held    (held_v[a]),
          .limit   (wd_limit),
          .expired (tmo_v[a])
        );
      end
    end else begin : g_no_wd
      logic unused_wd;
      assign unused_wd = ^{wd_limit, claim_v, held_v};
      assign tmo_v     = '0;
    end
  endgenerate

  assign cpu_timeout = tmo_v[0];
  assign fw_timeout  = tmo_v[1];
endmodule

// File: rtl/sema_chk.sv
`timescale 1ns/1ps
module sema_chk #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned CPU_BIT = 14,
  parameter int unsigned FW_BIT  = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_wr_en,
  input logic [REG_W-1:0] cpu_wr_mask,
  input logic             fw_wr_en,
  input logic [REG_W-1:0] fw_wr_mask,
  input logic [REG_W-1:0] sema_rd,
  input logic             cpu_grant,
  input logic             fw_grant,
  input logic             conflict,
  input logic             cpu_timeout,
  input logic             fw_timeout
);
  // R9
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_grant && fw_grant));

  // R3
  fw_flag_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fw_wr_en && fw_wr_mask[FW_BIT]) |=> $stable(sema_rd[FW_BIT]));

  // R3
  cpu_flag_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr_en && cpu_wr_mask[CPU_BIT]) |=> $stable(sema_rd[CPU_BIT]));

  // R5
  cpu_grant_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_grant |-> $past(sema_rd[CPU_BIT]));

  // R5
  fw_grant_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_grant |-> $past(sema_rd[FW_BIT]));

  // R6
  cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_grant && sema_rd[CPU_BIT]) |=> cpu_grant);

  // R6
  fw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_grant && sema_rd[FW_BIT]) |=> fw_grant);

  // R8
  tie_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (fw_grant && $past(sema_rd[CPU_BIT] && sema_rd[FW_BIT])));

  // R8
  tie_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> !conflict);

  // R10
  cpu_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_timeout |-> (sema_rd[CPU_BIT] && !cpu_grant));

  // R10
  fw_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_timeout |-> (sema_rd[FW_BIT] && !fw_grant));
endmodule

bind hw_own_sema sema_chk #(.REG_W(REG_W), .CPU_BIT(CPU_BIT), .FW_BIT(FW_BIT)) u_sema_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_wr_en   (cpu_wr_en),
  .cpu_wr_mask (cpu_wr_mask),
  .fw_wr_en    (fw_wr_en),
  .fw_wr_mask  (fw_wr_mask),
  .sema_rd     (sema_rd),
  .cpu_grant   (cpu_grant),
  .fw_grant    (fw_grant),
  .conflict    (conflict),
  .cpu_timeout (cpu_timeout),
  .fw_timeout  (fw_timeout)
);

// File: tb/test_hw_own_sema.sv
`timescale 1ns/1ps
module test_hw_own_sema;
  localparam int unsigned REG_W = 16;
  localparam int unsigned WD_W  = 16;
  localparam logic [15:0] CPU_F = 16'h4000;  // bit 14
  localparam logic [15:0] FW_F  = 16'h8000;  // bit 15

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cpu_wr_en, fw_wr_en;
  logic [REG_W-1:0] cpu_wr_data, cpu_wr_mask, fw_wr_data, fw_wr_mask;
  logic [WD_W-1:0]  wd_limit;
  logic [REG_W-1:0] sema_rd;
  logic             cpu_grant, fw_grant, conflict, cpu_timeout, fw_timeout;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;

  hw_own_sema i_hw_own_sema (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_wr_mask(cpu_wr_mask),
    .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data), .fw_wr_mask(fw_wr_mask),
    .wd_limit(wd_limit), .sema_rd(sema_rd),
    .cpu_grant(cpu_grant), .fw_grant(fw_grant), .conflict(conflict),
    .cpu_timeout(cpu_timeout), .fw_timeout(fw_timeout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // drive at falling edge, return at the falling edge after the taking edge
  task automatic wr2(input logic ce, input logic [15:0] cd, input logic [15:0] cm,
                     input logic fe, input logic [15:0] fd, input logic [15:0] fm);
    cpu_wr_en = ce; cpu_wr_data = cd; cpu_wr_mask = cm;
    fw_wr_en  = fe; fw_wr_data  = fd; fw_wr_mask  = fm;
    @(negedge clk);
    cpu_wr_en = 1'b0; fw_wr_en = 1'b0;
  endtask

  task automatic cpu_wr(input logic [15:0] d, input logic [15:0] m);
    wr2(1'b1, d, m, 1'b0, '0, '0);
  endtask

  task automatic fw_wr(input logic [15:0] d, input logic [15:0] m);
    wr2(1'b0, '0, '0, 1'b1, d, m);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cpu_wr_en = 1'b0; fw_wr_en = 1'b0;
    cpu_wr_data = '0; cpu_wr_mask = '0; fw_wr_data = '0; fw_wr_mask = '0;
    wd_limit = 16'd5;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 register", sema_rd, 0);
    chk("R1 grants", {cpu_grant, fw_grant}, 0);
    chk("R1 conflict", conflict, 0);
    chk("R1 timeouts", {cpu_timeout, fw_timeout}, 0);
  endtask

  task automatic t_solo();
    cpu_wr(CPU_F, CPU_F);
    chk("R2 cpu flag bit14", sema_rd, 32'h4000);
    chk("R5 cpu grant not yet", cpu_grant, 0);
    @(negedge clk);
    chk("R5 cpu grant", {cpu_grant, fw_grant}, 2'b10);
    cpu_wr(16'h0, CPU_F);
    chk("R7 cpu flag cleared", sema_rd, 0);
    @(negedge clk);
    chk("R7 cpu grant dropped", cpu_grant, 0);
    fw_wr(FW_F, FW_F);
    chk("R2 fw flag bit15", sema_rd, 32'h8000);
    @(negedge clk);
    chk("R5 fw grant", {cpu_grant, fw_grant}, 2'b01);
    fw_wr(16'h0, FW_F);
    @(negedge clk);
    chk("R7 fw grant dropped", fw_grant, 0);
  endtask

  task automatic t_protect();
    cpu_wr(FW_F, FW_F);
    chk("R3 cpu cannot set fw flag", sema_rd, 0);
    @(negedge clk);
    chk("R3 no fw grant", fw_grant, 0);
    fw_wr(CPU_F, CPU_F);
    chk("R3 fw cannot set cpu flag", sema_rd, 0);
    fw_wr(FW_F, FW_F);
    cpu_wr(16'h0, FW_F);
    chk("R3 cpu cannot clear fw flag", sema_rd, 32'h8000);
    fw_wr(16'h0, FW_F);
    @(negedge clk);
    chk("R3 idle after release", {sema_rd, cpu_grant, fw_grant}, 0);
  endtask

  task automatic t_masked();
    cpu_wr(16'h0123, 16'h0FFF);
    chk("R4 low bits", sema_rd, 32'h0123);
    cpu_wr(CPU_F, CPU_F);
    chk("R4 claim keeps low bits", sema_rd, 32'h4123);
    wr2(1'b1, 16'h0AAA, 16'h0F0F, 1'b1, 16'h0555, 16'h00FF);
    chk("R4 fw wins overlap", sema_rd, 32'h4A55);
    cpu_wr(16'h0, CPU_F);
    chk("R4 release keeps others", sema_rd, 32'h0A55);
    cpu_wr(16'h0, 16'h3FFF);
    chk("R4 clear low bits", sema_rd, 0);
    @(negedge clk);
  endtask

  task automatic t_contend();
    wd_limit = 16'd5;
    cpu_wr(CPU_F, CPU_F);
    @(negedge clk);
    fw_wr(FW_F, FW_F);
    chk("R6 both flags", sema_rd, 32'hC000);
    repeat (4) @(negedge clk);
    chk("R6 cpu keeps grant", {cpu_grant, fw_grant}, 2'b10);
    chk("R10 fw timeout not yet", fw_timeout, 0);
    @(negedge clk);
    chk("R10 fw timeout at limit", fw_timeout, 1);
    cpu_wr(16'h0, CPU_F);
    chk("R7 grant before handover", {cpu_grant, fw_grant}, 2'b10);
    @(negedge clk);
    chk("R7 handover to fw", {cpu_grant, fw_grant}, 2'b01);
    chk("R10 timeout cleared on grant", fw_timeout, 0);
    fw_wr(16'h0, FW_F);
    @(negedge clk);
    chk("R7 idle", {cpu_grant, fw_grant}, 0);
  endtask

  task automatic t_tie();
    wr2(1'b1, CPU_F, CPU_F, 1'b1, FW_F, FW_F);
    chk("R8 both flags", sema_rd, 32'hC000);
    chk("R8 no grant yet", {cpu_grant, fw_grant, conflict}, 0);
    @(negedge clk);
    chk("R8 fw wins tie", {cpu_grant, fw_grant}, 2'b01);
    chk("R8 conflict pulse", conflict, 1);
    chk("R9 single grant", cpu_grant & fw_grant, 0);
    @(negedge clk);
    chk("R8 conflict one cycle", conflict, 0);
    chk("R8 fw still holds", fw_grant, 1);
    fw_wr(16'h0, FW_F);
    @(negedge clk);
    chk("R7 cpu granted after tie", {cpu_grant, fw_grant}, 2'b10);
    cpu_wr(16'h0, CPU_F);
    @(negedge clk);
  endtask

  task automatic t_wd_off();
    wd_limit = 16'd0;
    fw_wr(FW_F, FW_F);
    @(negedge clk);
    cpu_wr(CPU_F, CPU_F);
    repeat (10) @(negedge clk);
    chk("R10 limit zero disables", cpu_timeout, 0);
    chk("R6 fw holds", {cpu_grant, fw_grant}, 2'b01);
    wd_limit = 16'd3;
    repeat (3) @(negedge clk);
    chk("R10 cpu timeout after limit", cpu_timeout, 1);
    cpu_wr(16'h0, CPU_F);
    chk("R10 timeout cleared on drop", cpu_timeout, 0);
    fw_wr(16'h0, FW_F);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_solo();
    t_protect();
    t_masked();
    t_contend();
    t_tie();
    t_wd_off();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end
endmodule